// File: doc/BRIEF.md
# Segment Register Load Validator

This block decides whether a selector, together with the 8-byte descriptor already read for it, may be placed into one of the eight segment-type registers of a protected-mode processor: code, stack, the four data registers, the local table register or the task register. The caller also supplies the current privilege level, the present flag of the cached local-table descriptor, and the kind of transfer that causes the load: plain move, jump, call, interrupt return or far return.

One cycle after a request, the block gives exactly one result. It either accepts the load and returns the descriptor to cache, or it reports one general-protection, not-present or stack fault with its error code. Many rules can apply to a single load. The block ranks them in a fixed order: the local-table check first, then the null selector, then type and privilege, and presence last. For loads into the code register it also reports whether the descriptor was a gate and whether the load starts a task switch. Those cases, the second descriptor fetch behind a gate, and the stack copy for a call gate are handled by other logic.

For a far return, the block also reports the privilege level that results from the load. The result stays on the outputs until the next request arrives.

Top module: `segld_check`

## Requirements
- R1: A request sampled on a rising edge with `req` high gives its result on the outputs after that edge, and `done` is high for exactly that one cycle. Destination codes are CS=0, SS=1, DS=2, ES=3, FS=4, GS=5, LDTR=6, TR=7. Kind codes are move=0, jump=1, call=2, interrupt return=3, far return=4. Fault codes are none=0, #GP=1, #NP=2, #SS=3. `accept` is high exactly when the fault code is 0. On a fault, `err_code` is the selector with bits 1:0 cleared, and `desc_out`, `via_gate` and `task_switch` are zero. On accept, `err_code` is zero.
- R2: The local-table check has the highest priority. A selector with bit 2 set, while `ldtr_present` is low and the destination is not LDTR, gives #GP.
- R3: A selector whose bits 15:2 are zero (bits 1:0 ignored) is accepted into LDTR, DS, ES, FS or GS with an all-zero `desc_out`. The same selector into CS, SS or TR gives #GP with error code 0.
- R4: On a jump or call into CS, a system descriptor whose type (bits 43:40) is a call gate (4'h4 or 4'hC) or a task gate (4'h5) is accepted with `via_gate` set. A task gate also sets `task_switch`. Interrupt gates, trap gates and every other system type give #GP.
- R5: A call gate or task gate whose DPL is below max(CPL, RPL) gives #GP.
- R6: Descriptor fields are: present bit 47, DPL bits 46:45, code/data flag bit 44 (0 means system), executable bit 43, conforming bit 42, and readable (code) or writable (data) bit 41. DS, ES, FS and GS reject system descriptors and execute-only code with #GP. SS rejects system descriptors, all code segments and read-only data with #GP.
- R7: In SS, DS, ES, FS and GS, a data segment or a non-conforming code segment with max(CPL, RPL) greater than DPL gives #GP. A readable conforming code segment in a data register skips this check.
- R8: CS accepts a code segment when it is conforming with DPL ≤ max(CPL, RPL), or non-conforming with DPL equal to max(CPL, RPL). Any other code segment, and any data segment, gives #GP.
- R9: A TSS (types 4'h1, 4'h3, 4'h9, 4'hB) loaded into CS by jump, call or interrupt return is accepted with `task_switch` set. A jump or call gives #GP when max(CPL, RPL) exceeds DPL. An interrupt return skips the privilege check. A move or far return of a TSS into CS gives #GP.
- R10: LDTR accepts only system type 4'h2. TR accepts only the four TSS types. Any other descriptor in these registers gives #GP.
- R11: The present bit is checked after all type and privilege checks. When it is clear, SS gets #SS and every other destination gets #NP.
- R12: A far return into CS that is accepted sets `cpl_out` to max(CPL, RPL). Every other request returns `cpl_out` equal to `req_cpl`.
- R13: After reset, all outputs are zero. When no request arrives, `accept`, `fault`, `err_code`, `desc_out`, `via_gate`, `task_switch` and `cpl_out` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Validate the presented load this cycle |
| req_dst | input | 3 | Destination register code |
| req_kind | input | 3 | Transfer kind code |
| req_cpl | input | 2 | Current privilege level |
| req_sel | input | 16 | Selector being loaded |
| req_desc | input | 64 | Descriptor already fetched for the selector |
| ldtr_present | input | 1 | Present flag of the cached local-table descriptor |
| done | output | 1 | One-cycle pulse: result updated |
| accept | output | 1 | Load allowed |
| fault | output | 2 | Fault code, 0 when accepted |
| err_code | output | 16 | Error code for the fault |
| desc_out | output | 64 | Descriptor to cache on accept |
| via_gate | output | 1 | Accepted load went through a gate |
| task_switch | output | 1 | Accepted load starts a task switch |
| cpl_out | output | 2 | Privilege level after the load |

## Verification
The result registers feed the ports directly, so a wrong priority or a wrong attribute decode shows up as a wrong fault code or error code in the cycle right after the request. A stale register, or a missing clock enable, shows up during idle cycles as outputs that change without a request. A vector table pairs loads that break two rules at once, such as a privilege mismatch together with a clear present bit, or a missing local table together with a clear present bit, so that every fixed ordering is tested at the ports.

// File: rtl/segld_pkg.sv
package segld_pkg;
  localparam int SEL_W   = 16;
  localparam int DESC_W  = 64;
  localparam int ACC_LSB = 40;
  localparam int ACC_W   = 8;
  localparam int PL_W    = 2;

  typedef enum logic [2:0] {
    DST_CS, DST_SS, DST_DS, DST_ES, DST_FS, DST_GS, DST_LDTR, DST_TR
  } dst_e;

  typedef enum logic [2:0] {
    LK_MOV, LK_JMP, LK_CALL, LK_IRET, LK_RETF
  } kind_e;

  typedef enum logic [1:0] {
    FLT_NONE, FLT_GP, FLT_NP, FLT_SS
  } flt_e;

  typedef struct packed {
    logic            present;
    logic [PL_W-1:0] dpl;
    logic            is_sys;
    logic            is_code;
    logic            conf;
    logic            readable;
    logic            writable;
    logic            is_ldt;
    logic            is_tss;
    logic            is_callgate;
    logic            is_taskgate;
  } attr_t;
endpackage

// File: rtl/segld_decode.sv
module segld_decode
  import segld_pkg::*;
(
  input  logic [ACC_W-1:0] acc,
  output attr_t            attr
);
  logic [3:0] ty;

  always_comb begin
    ty               = acc[3:0];
    attr.present     = acc[7];
    attr.dpl         = acc[6:5];
    attr.is_sys      = ~acc[4];
    attr.is_code     = acc[4] & ty[3];
    attr.conf        = ty[2];
    attr.readable    = ty[1];
    attr.writable    = ty[1];
    attr.is_ldt      = ~acc[4] & (ty == 4'h2);
    attr.is_tss      = ~acc[4] & ~ty[2] & ty[0];
    attr.is_callgate = ~acc[4] & (ty[2:0] == 3'b100);
    attr.is_taskgate = ~acc[4] & (ty == 4'h5);
  end
endmodule

// File: rtl/segld_rules.sv
module segld_rules
  import segld_pkg::*;
(
  input  dst_e            dst,
  input  kind_e           kind,
  input  logic [PL_W-1:0] cpl,
  input  logic [SEL_W-1:0] sel,
  input  logic            ldtr_present,
  input  attr_t           attr,
  output flt_e            fault,
  output logic            gate,
  output logic            tsw,
  output logic            null_load,
  output logic [PL_W-1:0] new_cpl
);
  logic [PL_W-1:0] rpl;
  logic [PL_W-1:0] eff;
  logic            sel_null;
  logic            jmpcall;
  logic            type_bad;
  logic            priv_bad;

  always_comb begin
    rpl      = sel[PL_W-1:0];
    eff      = (cpl > rpl) ? cpl : rpl;
    sel_null = (sel[SEL_W-1:2] == '0);
    jmpcall  = (kind == LK_JMP) || (kind == LK_CALL);
  end

  // Fixed ranking: table check, null selector, type and privilege, presence.
  always_comb begin
    fault     = FLT_NONE;
    gate      = 1'b0;
    tsw       = 1'b0;
    null_load = 1'b0;
    type_bad  = 1'b0;
    priv_bad  = 1'b0;
    new_cpl   = cpl;
    if (sel[2] && !ldtr_present && (dst != DST_LDTR)) begin
      fault = FLT_GP;
    end else if (sel_null) begin
      if ((dst == DST_CS) || (dst == DST_SS) || (dst == DST_TR)) fault = FLT_GP;
      else null_load = 1'b1;
    end else begin
      case (dst)
        DST_CS: begin
          if (attr.is_sys) begin
            if (jmpcall && (attr.is_callgate || attr.is_taskgate)) begin
              gate     = 1'b1;
              tsw      = attr.is_taskgate;
              priv_bad = attr.dpl < eff;
            end else if (attr.is_tss && (jmpcall || (kind == LK_IRET))) begin
              tsw      = 1'b1;
              priv_bad = (kind != LK_IRET) && (eff > attr.dpl);
            end else begin
              type_bad = 1'b1;
            end
          end else if (!attr.is_code) begin
            type_bad = 1'b1;
          end else if (attr.conf) begin
            priv_bad = attr.dpl > eff;
          end else begin
            priv_bad = attr.dpl != eff;
          end
        end
        DST_SS: begin
          type_bad = attr.is_sys | attr.is_code | ~attr.writable;
          priv_bad = eff > attr.dpl;
        end
        DST_LDTR: type_bad = ~attr.is_ldt;
        DST_TR:   type_bad = ~attr.is_tss;
        default: begin
          type_bad = attr.is_sys | (attr.is_code & ~attr.readable);
          priv_bad = ~(attr.is_code & attr.conf) & (eff > attr.dpl);
        end
      endcase
      if (type_bad || priv_bad) fault = FLT_GP;
      else if (!attr.present) fault = (dst == DST_SS) ? FLT_SS : FLT_NP;
      if ((kind == LK_RETF) && (dst == DST_CS) && !gate && (fault == FLT_NONE))
        new_cpl = eff;
    end
  end
endmodule

// File: rtl/segld_check.sv
module segld_check
  import segld_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [2:0]        req_dst,
  input  logic [2:0]        req_kind,
  input  logic [PL_W-1:0]   req_cpl,
  input  logic [SEL_W-1:0]  req_sel,
  input  logic [DESC_W-1:0] req_desc,
  input  logic              ldtr_present,
  output logic              done,
  output logic              accept,
  output logic [1:0]        fault,
  output logic [SEL_W-1:0]  err_code,
  output logic [DESC_W-1:0] desc_out,
  output logic              via_gate,
  output logic              task_switch,
  output logic [PL_W-1:0]   cpl_out
);
  localparam logic [SEL_W-1:0] ERR_MASK = {{(SEL_W-2){1'b1}}, 2'b00};

  logic              rst_s1, rst_sync_n;
  attr_t             attr;
  flt_e              flt_c;
  logic              gate_c, tsw_c, null_c;
  logic [PL_W-1:0]   cpl_c;

  logic              done_d, accept_d, gate_d, tsw_d;
  logic [1:0]        fault_d;
  logic [SEL_W-1:0]  err_d;
  logic [DESC_W-1:0] desc_d;
  logic [PL_W-1:0]   cpl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  segld_decode u_decode (
    .acc  (req_desc[ACC_LSB +: ACC_W]),
    .attr (attr)
  );

  segld_rules u_rules (
    .dst          (dst_e'(req_dst)),
    .kind         (kind_e'(req_kind)),
    .cpl          (req_cpl),
    .sel          (req_sel),
    .ldtr_present (ldtr_present),
    .attr         (attr),
    .fault        (flt_c),
    .gate         (gate_c),
    .tsw          (tsw_c),
    .null_load    (null_c),
    .new_cpl      (cpl_c)
  );

  always_comb begin
    done_d   = req;
    accept_d = (flt_c == FLT_NONE);
    fault_d  = flt_c;
    err_d    = accept_d ? '0 : (req_sel & ERR_MASK);
    desc_d   = (accept_d && !null_c) ? req_desc : '0;
    gate_d   = accept_d & gate_c;
    tsw_d    = accept_d & tsw_c;
    cpl_d    = cpl_c;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      done        <= 1'b0;
      accept      <= 1'b0;
      fault       <= '0;
      err_code    <= '0;
      desc_out    <= '0;
      via_gate    <= 1'b0;
      task_switch <= 1'b0;
      cpl_out     <= '0;
    end else begin
      done <= done_d;
      if (req) begin
        accept      <= accept_d;
        fault       <= fault_d;
        err_code    <= err_d;
        desc_out    <= desc_d;
        via_gate    <= gate_d;
        task_switch <= tsw_d;
        cpl_out     <= cpl_d;
      end
    end
  end

  AST_RESULT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req |=> done); // R1
  AST_ACCEPT_XOR_FAULT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |-> (accept == (fault == 2'd0))); // R1
  AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done && !accept) |-> (desc_out == '0 && !via_gate && !task_switch && err_code[1:0] == 2'b00)); // R1
  AST_LDT_FIRST: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req && req_sel[2] && !ldtr_present && req_dst != 3'd6) |=> (fault == 2'd1)); // R2
  AST_NULL_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req && req_sel[SEL_W-1:2] == '0 && req_dst >= 3'd2 && req_dst <= 3'd6) |=> (accept && desc_out == '0)); // R3
  AST_STACK_FAULT_ONLY_SS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req && req_dst != 3'd1) |=> (fault != 2'd3)); // R11
  AST_CPL_NEVER_RAISED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req |=> (cpl_out >= $past(req_cpl))); // R12
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req |=> ($stable(accept) && $stable(fault) && $stable(err_code) && $stable(desc_out) && $stable(cpl_out))); // R13
endmodule

// File: tb/test_segld_check.sv
module test_segld_check;
  localparam int RW = 88;
  localparam int NV = 41;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req;
  logic [2:0]  req_dst, req_kind;
  logic [1:0]  req_cpl;
  logic [15:0] req_sel;
  logic [63:0] req_desc;
  logic        ldtr_present;
  logic        done, accept, via_gate, task_switch;
  logic [1:0]  fault, cpl_out;
  logic [15:0] err_code;
  logic [63:0] desc_out;

  int nchk = 0;
  int nbad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  segld_check i_segld_check (
    .clk(clk), .rst_n(rst_n), .req(req), .req_dst(req_dst), .req_kind(req_kind),
    .req_cpl(req_cpl), .req_sel(req_sel), .req_desc(req_desc), .ldtr_present(ldtr_present),
    .done(done), .accept(accept), .fault(fault), .err_code(err_code), .desc_out(desc_out),
    .via_gate(via_gate), .task_switch(task_switch), .cpl_out(cpl_out)
  );

  // {rq, dst, kind, cpl, ldtr_p, sel, access, fault, cpl_out, gate, task}
  localparam logic [42:0] VEC [NV] = '{
    {4'd7, 3'd2,3'd0,2'd0,1'b1,16'h0010,8'h93,2'd0,2'd0,1'b0,1'b0}, // R7 data ok
    {4'd7, 3'd2,3'd0,2'd3,1'b1,16'h0013,8'h93,2'd1,2'd3,1'b0,1'b0}, // R7 cpl above dpl
    {4'd7, 3'd2,3'd0,2'd3,1'b1,16'h0013,8'hF3,2'd0,2'd3,1'b0,1'b0}, // R7 equal
    {4'd7, 3'd2,3'd0,2'd0,1'b1,16'h0013,8'h93,2'd1,2'd0,1'b0,1'b0}, // R7 rpl above dpl
    {4'd6, 3'd3,3'd0,2'd0,1'b1,16'h0018,8'h99,2'd1,2'd0,1'b0,1'b0}, // R6 execute-only
    {4'd7, 3'd4,3'd0,2'd3,1'b1,16'h001B,8'h9F,2'd0,2'd3,1'b0,1'b0}, // R7 conforming skip
    {4'd6, 3'd5,3'd0,2'd0,1'b1,16'h0020,8'h89,2'd1,2'd0,1'b0,1'b0}, // R6 system in GS
    {4'd6, 3'd1,3'd0,2'd0,1'b1,16'h0028,8'h91,2'd1,2'd0,1'b0,1'b0}, // R6 read-only SS
    {4'd11,3'd1,3'd0,2'd0,1'b1,16'h0028,8'h13,2'd3,2'd0,1'b0,1'b0}, // R11 SS absent
    {4'd11,3'd2,3'd0,2'd0,1'b1,16'h0028,8'h13,2'd2,2'd0,1'b0,1'b0}, // R11 DS absent
    {4'd11,3'd1,3'd0,2'd0,1'b1,16'h002B,8'h13,2'd1,2'd0,1'b0,1'b0}, // R11 privilege first
    {4'd2, 3'd2,3'd0,2'd0,1'b0,16'h0014,8'h93,2'd1,2'd0,1'b0,1'b0}, // R2 no local table
    {4'd2, 3'd6,3'd0,2'd0,1'b0,16'h0034,8'h82,2'd0,2'd0,1'b0,1'b0}, // R2 LDTR exempt
    {4'd10,3'd6,3'd0,2'd0,1'b1,16'h0030,8'h93,2'd1,2'd0,1'b0,1'b0}, // R10 data in LDTR
    {4'd3, 3'd6,3'd0,2'd0,1'b1,16'h0003,8'h93,2'd0,2'd0,1'b0,1'b0}, // R3 null LDTR
    {4'd3, 3'd2,3'd0,2'd0,1'b0,16'h0000,8'h93,2'd0,2'd0,1'b0,1'b0}, // R3 null DS
    {4'd3, 3'd1,3'd0,2'd0,1'b1,16'h0000,8'h93,2'd1,2'd0,1'b0,1'b0}, // R3 null SS
    {4'd3, 3'd0,3'd1,2'd0,1'b1,16'h0000,8'h9B,2'd1,2'd0,1'b0,1'b0}, // R3 null CS
    {4'd3, 3'd7,3'd0,2'd0,1'b1,16'h0002,8'h89,2'd1,2'd0,1'b0,1'b0}, // R3 null TR
    {4'd10,3'd7,3'd0,2'd0,1'b1,16'h0038,8'h8B,2'd0,2'd0,1'b0,1'b0}, // R10 busy TSS
    {4'd10,3'd7,3'd0,2'd0,1'b1,16'h0038,8'h9B,2'd1,2'd0,1'b0,1'b0}, // R10 code in TR
    {4'd10,3'd7,3'd0,2'd0,1'b1,16'h0038,8'h82,2'd1,2'd0,1'b0,1'b0}, // R10 LDT in TR
    {4'd8, 3'd0,3'd1,2'd0,1'b1,16'h0008,8'h9B,2'd0,2'd0,1'b0,1'b0}, // R8 equal
    {4'd8, 3'd0,3'd1,2'd3,1'b1,16'h000B,8'h9B,2'd1,2'd3,1'b0,1'b0}, // R8 nonconf mismatch
    {4'd8, 3'd0,3'd1,2'd3,1'b1,16'h000B,8'h9F,2'd0,2'd3,1'b0,1'b0}, // R8 conforming
    {4'd8, 3'd0,3'd2,2'd0,1'b1,16'h0008,8'hFF,2'd1,2'd0,1'b0,1'b0}, // R8 conf dpl high
    {4'd8, 3'd0,3'd1,2'd0,1'b1,16'h0008,8'h93,2'd1,2'd0,1'b0,1'b0}, // R8 data in CS
    {4'd5, 3'd0,3'd2,2'd3,1'b1,16'h0043,8'hEC,2'd0,2'd3,1'b1,1'b0}, // R5 call gate ok
    {4'd5, 3'd0,3'd2,2'd3,1'b1,16'h0043,8'h8C,2'd1,2'd3,1'b0,1'b0}, // R5 gate dpl low
    {4'd4, 3'd0,3'd1,2'd0,1'b1,16'h0040,8'h8E,2'd1,2'd0,1'b0,1'b0}, // R4 interrupt gate
    {4'd4, 3'd0,3'd1,2'd0,1'b1,16'h0040,8'hE5,2'd0,2'd0,1'b1,1'b1}, // R4 task gate
    {4'd9, 3'd0,3'd1,2'd0,1'b1,16'h0048,8'h89,2'd0,2'd0,1'b0,1'b1}, // R9 jump to TSS
    {4'd9, 3'd0,3'd3,2'd3,1'b1,16'h0048,8'h89,2'd0,2'd3,1'b0,1'b1}, // R9 return skips priv
    {4'd9, 3'd0,3'd1,2'd3,1'b1,16'h0048,8'h89,2'd1,2'd3,1'b0,1'b0}, // R9 jump priv fail
    {4'd12,3'd0,3'd4,2'd0,1'b1,16'h000B,8'hFB,2'd0,2'd3,1'b0,1'b0}, // R12 outer return
    {4'd12,3'd0,3'd4,2'd0,1'b1,16'h0008,8'h9B,2'd0,2'd0,1'b0,1'b0}, // R12 same level
    {4'd9, 3'd0,3'd0,2'd0,1'b1,16'h0048,8'h89,2'd1,2'd0,1'b0,1'b0}, // R9 move TSS
    {4'd11,3'd0,3'd1,2'd0,1'b1,16'h0008,8'h1B,2'd2,2'd0,1'b0,1'b0}, // R11 code absent
    {4'd11,3'd0,3'd2,2'd0,1'b1,16'h0008,8'h6C,2'd2,2'd0,1'b0,1'b0}, // R11 gate absent
    {4'd2, 3'd2,3'd0,2'd0,1'b0,16'h0014,8'h13,2'd1,2'd0,1'b0,1'b0}, // R2 beats absent
    {4'd6, 3'd1,3'd0,2'd0,1'b1,16'h0028,8'h9B,2'd1,2'd0,1'b0,1'b0}  // R6 code in SS
  };

  function automatic logic [63:0] mkdesc(input logic [7:0] acc);
    return {8'h00, 8'hCF, acc, 24'h123400, 16'hFFFF};
  endfunction

  function automatic logic [RW-1:0] obs();
    return {done, accept, fault, err_code, desc_out, via_gate, task_switch, cpl_out};
  endfunction

  task automatic check(input string tag, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [42:0] v);
    req          = 1'b1;
    req_dst      = v[38:36];
    req_kind     = v[35:33];
    req_cpl      = v[32:31];
    ldtr_present = v[30];
    req_sel      = v[29:14];
    req_desc     = mkdesc(v[13:6]);
  endtask

  function automatic logic [RW-1:0] expect_of(input logic [42:0] v, input logic dn);
    logic [1:0]  f;
    logic [15:0] s;
    logic [63:0] d;
    f = v[5:4];
    s = v[29:14];
    if (f != 2'd0 || s[15:2] == 14'd0) d = '0;
    else d = mkdesc(v[13:6]);
    return {dn, (f == 2'd0), f, (f != 2'd0) ? (s & 16'hFFFC) : 16'h0000, d, v[1], v[0], v[3:2]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nbad++;
      $display("FAIL R13 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

  initial begin
    logic [RW-1:0] held;
    rst_n = 1'b0; req = 1'b0; req_dst = '0; req_kind = '0; req_cpl = '0;
    req_sel = '0; req_desc = '0; ldtr_present = 1'b0;
    repeat (3) @(negedge clk);
    check("R13 reset state", obs(), '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R13 idle after reset", obs(), '0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      req = 1'b0;
      check($sformatf("R%0d vector %0d", VEC[i][42:39], i), obs(), expect_of(VEC[i], 1'b1));
    end

    // R13: result held with no request, done falls (R1)
    drive(VEC[27]);
    @(negedge clk);
    req = 1'b0;
    req_sel = 16'hFFFF; req_desc = '1; req_dst = 3'd1;
    held = expect_of(VEC[27], 1'b0);
    repeat (4) @(negedge clk);
    check("R13 hold while idle", obs(), held);

    // R1: back-to-back requests each land one cycle later
    drive(VEC[8]);
    @(negedge clk);
    check("R1 first of pair", obs(), expect_of(VEC[8], 1'b1));
    drive(VEC[34]);
    @(negedge clk);
    req = 1'b0;
    check("R1 second of pair", obs(), expect_of(VEC[34], 1'b1));

    // R13: reset clears held result
    rst_n = 1'b0;
    #1;
    check("R13 reset clears", obs(), '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R13 after second reset", obs(), '0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule